// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block sits between a CPU register bus and an on-chip nonvolatile store. Software selects a target space (data bytes, program rows or configuration cells), loads a pointer and data, and then sets a start bit in a control register. The block issues one request to the memory array over a valid/ready port. For a program or erase operation it then runs its own programming timer. When the timer ends it clears the start bit and raises a sticky completion flag.

A program write moves a whole row at once. The row comes from a bank of byte-wide holding registers, which software fills one byte at a time through a latch register. The low pointer bits select which holding byte is written. A write or erase is accepted only right after a two-byte unlock pattern has been written to a register that stores nothing. A request that is not correctly prepared is dropped and flagged as an error. A warm reset that lands during programming is also recorded as an error, and the target-select bits are left intact so the failure can be traced.

The memory port follows valid/ready rules. The block raises `mem_req_valid` and holds the operation, space, address and byte stable until the cycle in which `mem_req_ready` is high. That cycle is the transfer. `mem_rdata` is sampled in the transfer cycle of a read. The memory may hold `mem_req_ready` low for any number of cycles. The programming timer starts only after the transfer.

Top module: `nvm_ctrl`

## Requirements
- R1: Register map on `bus_addr`: 0 control, 1 unlock, 2 data, 3 pointer bits 7:0, 4 pointer upper bits, 5 holding latch, 6 completion flag (bit 0). Control bit order from bit 7 down to bit 0: program select, configuration select, spare, row-erase enable, error, write enable, write start, read start. The spare bit always reads 0, and the unlock register always reads 0x00.
- R2: A request carries `mem_space` 2 (configuration) when configuration select is 1, whatever program select holds. Otherwise it carries 1 (program) when program select is 1 and 0 (data) when it is 0.
- R3: Writing 0 to write start or read start never clears them. Only completion clears them.
- R4: Setting read start with both select bits 0 issues a read request (`mem_op` 0) at the pointer. Read start clears one cycle after the transfer, and the data register then holds `mem_rdata`. Read start cannot be set while program select or configuration select is 1.
- R5: A write or erase starts only when the last two bus writes before the control write were 0x55 then 0xAA to the unlock register. Otherwise the request is dropped and the error bit reads 1.
- R6: Write enable resets to 0. A start request whose write-enable bit is 0 is dropped and sets the error bit.
- R7: With row-erase enable set, write start issues `mem_op` 3 at the pointer rounded down to a row boundary. Row-erase enable clears when that erase completes.
- R8: Write start clears exactly PROG_CYCLES clock edges after the transfer edge. While an operation is pending, further write or read start requests are ignored and set no error.
- R9: A warm reset (`rst_n` low) during a write or erase sets the error bit and clears write start, write enable, row-erase enable and the completion flag. It keeps program select and configuration select. Power-on reset (`por_n` low) clears every bit.
- R10: The completion flag and `irq` go to 1 when a write or erase completes. They stay 1 until software writes register 6 with bit 0 equal to 0.
- R11: A program-space write without erase issues `mem_op` 2 at the row base. Byte i of `mem_wrow` is the holding byte last written via register 5 while pointer bits 4:0 were i. Register 5 reads back the byte selected by the pointer.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its fields stay stable. A data or configuration write uses `mem_op` 1 and carries the data register on `mem_wbyte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_op | output | 2 | 0 read, 1 byte write, 2 row write, 3 row erase |
| mem_space | output | 2 | 0 data, 1 program, 2 configuration |
| mem_addr | output | ADDR_W | Byte or row-base address |
| mem_wbyte | output | 8 | Byte for a byte write |
| mem_wrow | output | ROW_BYTES*8 | Row data, byte i in bits 8i+7:8i |
| mem_rdata | input | 8 | Read data, valid in a read transfer |

## Verification
The pending-operation state shows up on the port and in the control register within one cycle of a start. A lost or spurious state therefore appears as a missing request, an extra request or a stuck start bit before the next bus access. A wrong unlock or enable decision shows up at the control write itself: either a transfer appears when it should not, or the error bit is missing. An error in the timer is visible only at completion, as a start bit that clears a cycle early or late. The bench therefore samples it exactly at the expected edge and the edge before it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WBYTE = 2'd1,
    OP_WROW  = 2'd2,
    OP_ERASE = 2'd3
  } nvm_op_e;

  typedef enum logic [1:0] {
    SP_DATA = 2'd0,
    SP_PROG = 2'd1,
    SP_CFG  = 2'd2
  } nvm_space_e;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_UNLOCK = 3'd1;
  localparam logic [2:0] RA_DATA   = 3'd2;
  localparam logic [2:0] RA_PTRL   = 3'd3;
  localparam logic [2:0] RA_PTRH   = 3'd4;
  localparam logic [2:0] RA_HOLD   = 3'd5;
  localparam logic [2:0] RA_IRQ    = 3'd6;

  localparam int B_PGM  = 7;
  localparam int B_CFG  = 6;
  localparam int B_FREE = 4;
  localparam int B_WERR = 3;
  localparam int B_WREN = 2;
  localparam int B_WR   = 1;
  localparam int B_RD   = 0;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       armed
);
  logic [1:0] stage_q;
  logic       key_wr;

  assign key_wr = bus_wr && (bus_addr == RA_UNLOCK);

  // Any bus write that does not continue the pattern drops back to stage 0,
  // so the key must be the last two writes before the control write.
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      stage_q <= 2'd0;
    end else if (bus_wr) begin
      if (key_wr && bus_wdata == KEY_FIRST)
        stage_q <= 2'd1;
      else if (key_wr && bus_wdata == KEY_SECOND && stage_q == 2'd1)
        stage_q <= 2'd2;
      else
        stage_q <= 2'd0;
    end
  end

  assign armed = (stage_q == 2'd2);
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
  parameter int ROW_BYTES = 32,
  parameter int IDX_W     = $clog2(ROW_BYTES)
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [ROW_BYTES*8-1:0] row
);
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!por_n)
        byte_q <= 8'hFF;
      else if (wr_en && idx == IDX_W'(g))
        byte_q <= wdata;
    end
    assign row[g*8 +: 8] = byte_q;
  end

  assign rdata = row[idx*8 +: 8];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [1:0]        op_in,
  input  logic [1:0]        space_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        wbyte_in,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [1:0]        req_space,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wbyte,
  output logic              rd_done,
  output logic              wr_done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RREQ, S_WREQ, S_TIME} seq_st_e;

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        op_q;
  logic [1:0]        space_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wbyte_q;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_READ;
      space_q <= SP_DATA;
      addr_q  <= '0;
      wbyte_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_wr || start_rd) begin
            st_q    <= start_wr ? S_WREQ : S_RREQ;
            op_q    <= op_in;
            space_q <= space_in;
            addr_q  <= addr_in;
            wbyte_q <= wbyte_in;
          end
        end
        S_RREQ: if (req_ready) st_q <= S_IDLE;
        S_WREQ: begin
          if (req_ready) begin
            st_q  <= S_TIME;
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
          end
        end
        S_TIME: begin
          if (cnt_q == '0) st_q <= S_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign req_valid = (st_q == S_RREQ) || (st_q == S_WREQ);
  assign req_op    = op_q;
  assign req_space = space_q;
  assign req_addr  = addr_q;
  assign req_wbyte = wbyte_q;
  assign rd_done   = (st_q == S_RREQ) && req_ready;
  assign wr_done   = (st_q == S_TIME) && (cnt_q == '0);
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ROW_BYTES   = 32,
  parameter int PROG_CYCLES = 2000
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic [2:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   irq,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [1:0]             mem_op,
  output logic [1:0]             mem_space,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wbyte,
  output logic [ROW_BYTES*8-1:0] mem_wrow,
  input  logic [7:0]             mem_rdata
);
  localparam int IDX_W = $clog2(ROW_BYTES);
  localparam logic [ADDR_W-1:0] ROW_MASK = ~ADDR_W'(ROW_BYTES - 1);

  logic pgm_q, cfg_q, free_q, werr_q, wren_q, wr_q, rd_q, irq_q;
  logic [7:0]        dat_q;
  logic [ADDR_W-1:0] ptr_q;

  logic armed, busy, rd_done, wr_done;
  logic ctrl_wr, want_wr, legal_wr, bad_wr, want_rd;
  logic [1:0] space_sel, op_sel;
  logic [ADDR_W-1:0] addr_sel;
  logic [7:0] hold_rdata;
  logic [1:0] seq_op;

  nvm_unlock u_unlock (
    .clk, .por_n, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .armed
  );

  nvm_hold_buf #(.ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_hold (
    .clk,
    .por_n,
    .wr_en (bus_wr && bus_addr == RA_HOLD),
    .idx   (ptr_q[IDX_W-1:0]),
    .wdata (bus_wdata),
    .rdata (hold_rdata),
    .row   (mem_wrow)
  );

  // Start decode uses the select bits carried by the same control write.
  assign ctrl_wr  = bus_wr && (bus_addr == RA_CTRL);
  assign want_wr  = ctrl_wr && bus_wdata[B_WR] && !busy;
  assign legal_wr = want_wr && armed && bus_wdata[B_WREN];
  assign bad_wr   = want_wr && !legal_wr;
  assign want_rd  = ctrl_wr && bus_wdata[B_RD] && !busy && !want_wr &&
                    !bus_wdata[B_PGM] && !bus_wdata[B_CFG];

  always_comb begin
    if (bus_wdata[B_CFG])      space_sel = SP_CFG;
    else if (bus_wdata[B_PGM]) space_sel = SP_PROG;
    else                       space_sel = SP_DATA;

    if (!want_wr)                op_sel = OP_READ;
    else if (bus_wdata[B_FREE])  op_sel = OP_ERASE;
    else if (space_sel == SP_PROG) op_sel = OP_WROW;
    else                         op_sel = OP_WBYTE;

    addr_sel = (op_sel == OP_ERASE || op_sel == OP_WROW) ? (ptr_q & ROW_MASK) : ptr_q;
  end

  nvm_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk,
    .por_n,
    .rst_n,
    .start_wr  (legal_wr),
    .start_rd  (want_rd),
    .op_in     (op_sel),
    .space_in  (space_sel),
    .addr_in   (addr_sel),
    .wbyte_in  (dat_q),
    .busy,
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_op    (seq_op),
    .req_space (mem_space),
    .req_addr  (mem_addr),
    .req_wbyte (mem_wbyte),
    .rd_done,
    .wr_done
  );

  assign mem_op = seq_op;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pgm_q  <= 1'b0;
      cfg_q  <= 1'b0;
      free_q <= 1'b0;
      werr_q <= 1'b0;
      wren_q <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      irq_q  <= 1'b0;
      dat_q  <= '0;
      ptr_q  <= '0;
    end else if (!rst_n) begin
      // Targets are kept so an aborted operation can be traced.
      werr_q <= werr_q | wr_q;
      free_q <= 1'b0;
      wren_q <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        pgm_q  <= bus_wdata[B_PGM];
        cfg_q  <= bus_wdata[B_CFG];
        free_q <= bus_wdata[B_FREE];
        werr_q <= bus_wdata[B_WERR] | bad_wr;
        wren_q <= bus_wdata[B_WREN];
      end
      if (legal_wr) wr_q <= 1'b1;
      if (want_rd)  rd_q <= 1'b1;

      if (bus_wr && bus_addr == RA_DATA) dat_q <= bus_wdata;
      if (bus_wr && bus_addr == RA_PTRL) ptr_q[7:0] <= bus_wdata;
      if (bus_wr && bus_addr == RA_PTRH) ptr_q[ADDR_W-1:8] <= bus_wdata[ADDR_W-9:0];
      if (bus_wr && bus_addr == RA_IRQ && !bus_wdata[0]) irq_q <= 1'b0;

      if (rd_done) begin
        rd_q  <= 1'b0;
        dat_q <= mem_rdata;
      end
      if (wr_done) begin
        wr_q  <= 1'b0;
        irq_q <= 1'b1;
        if (seq_op == OP_ERASE) free_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_CTRL:   bus_rdata = {pgm_q, cfg_q, 1'b0, free_q, werr_q, wren_q, wr_q, rd_q};
      RA_DATA:   bus_rdata = dat_q;
      RA_PTRL:   bus_rdata = ptr_q[7:0];
      RA_PTRH:   bus_rdata = 8'(ptr_q >> 8);
      RA_HOLD:   bus_rdata = hold_rdata;
      RA_IRQ:    bus_rdata = {7'd0, irq_q};
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int ROW_BYTES = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              irq,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [1:0]        mem_op,
  input logic [1:0]        mem_space,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wbyte,
  input logic              wr_q,
  input logic              rd_q,
  input logic              werr_q,
  input logic              wr_done
);
  localparam int IDX_W = $clog2(ROW_BYTES);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_op) &&
      $stable(mem_space) && $stable(mem_addr) && $stable(mem_wbyte)));

  a_r2_space_legal: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    mem_req_valid |-> (mem_space != 2'd3));

  a_r7_erase_row_base: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (mem_req_valid && mem_op == 2'd3) |-> (mem_addr[IDX_W-1:0] == '0));

  a_r3_wr_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_q && !wr_done) |=> wr_q);

  a_r4_rd_one_cycle: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rd_q && mem_req_valid && mem_req_ready) |=> !rd_q);

  a_r8_single_op: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !(wr_q && rd_q));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (irq && !(bus_wr && bus_addr == 3'd6 && !bus_wdata[0])) |=> irq);

  a_r9_abort_flag: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && wr_q) |=> werr_q);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) chk_i (
  .clk           (clk),
  .por_n         (por_n),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .irq           (irq),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_op        (mem_op),
  .mem_space     (mem_space),
  .mem_addr      (mem_addr),
  .mem_wbyte     (mem_wbyte),
  .wr_q          (wr_q),
  .rd_q          (rd_q),
  .werr_q        (werr_q),
  .wr_done       (wr_done)
);

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;
  localparam int AW = 16;
  localparam int RB = 32;
  localparam int PC = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          por_n, rst_n, bus_wr, irq, mem_req_valid, ready_ctl;
  logic [2:0]    bus_addr;
  logic [7:0]    bus_wdata, bus_rdata, mem_wbyte, mem_rdata;
  logic [1:0]    mem_op, mem_space;
  logic [AW-1:0] mem_addr;
  logic [RB*8-1:0] mem_wrow;

  nvm_ctrl #(.ADDR_W(AW), .ROW_BYTES(RB), .PROG_CYCLES(PC)) dut_i (
    .clk, .por_n, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .irq,
    .mem_req_valid, .mem_req_ready(ready_ctl), .mem_op, .mem_space, .mem_addr,
    .mem_wbyte, .mem_wrow, .mem_rdata
  );

  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  int hs_n = 0;
  always @(posedge clk) if (por_n && rst_n && mem_req_valid && ready_ctl) hs_n <= hs_n + 1;

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic unlock();
    bw(3'd1, 8'h55);
    bw(3'd1, 8'hAA);
  endtask

  // {is_read, addr, data, expected}
  localparam logic [19:0] VEC [12] = '{
    {1'b0, 3'd3, 8'hA5, 8'h00}, {1'b1, 3'd3, 8'h00, 8'hA5},
    {1'b0, 3'd4, 8'h3C, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h3C},
    {1'b0, 3'd1, 8'h55, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b0, 3'd2, 8'h96, 8'h00}, {1'b1, 3'd2, 8'h00, 8'h96},
    {1'b0, 3'd0, 8'hA4, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h84},
    {1'b0, 3'd0, 8'h00, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int h0;
    logic row_ok;
    por_n = 1'b0; rst_n = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
    ready_ctl = 1'b1;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    br(3'd0, v); check("R6 reset ctrl", v, 8'h00);
    check("R10 reset irq", irq, 1'b0);
    check("R12 reset valid", mem_req_valid, 1'b0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][19]) begin
        br(VEC[i][18:16], v);
        check($sformatf("R1 vector %0d", i), v, VEC[i][7:0]);
      end else begin
        bw(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R4 read
    bw(3'd3, 8'h12); bw(3'd4, 8'h00);
    bw(3'd0, 8'h01);
    br(3'd0, v); check("R4 rd set", v, 8'h01);
    check("R4 read op", {mem_req_valid, mem_op, mem_space, mem_addr}, {1'b1, 2'd0, 2'd0, 16'h0012});
    @(negedge clk);
    br(3'd0, v); check("R4 rd cleared", v, 8'h00);
    br(3'd2, v); check("R4 read data", v, 8'h48);
    h0 = hs_n;
    bw(3'd0, 8'h81);
    br(3'd0, v); check("R4 rd blocked pgm", v, 8'h80);
    bw(3'd0, 8'h41);
    br(3'd0, v); check("R4 rd blocked cfg", v, 8'h40);
    check("R4 no request", hs_n, h0);

    // R5 no unlock / broken unlock, R6 enable
    bw(3'd0, 8'h06);
    br(3'd0, v); check("R5 no key", v, 8'h0C);
    bw(3'd0, 8'h00);
    bw(3'd1, 8'h55); bw(3'd3, 8'h00); bw(3'd1, 8'hAA);
    bw(3'd0, 8'h06);
    br(3'd0, v); check("R5 broken key", v, 8'h0C);
    bw(3'd0, 8'h00);
    unlock();
    bw(3'd0, 8'h02);
    br(3'd0, v); check("R6 enable low", v, 8'h08);
    check("R5 R6 no request", hs_n, h0);
    bw(3'd0, 8'h00);

    // R12 byte write + R8 timer + R10 flag
    bw(3'd2, 8'h3C); bw(3'd3, 8'h21); bw(3'd4, 8'h00);
    unlock();
    bw(3'd0, 8'h06);
    br(3'd0, v); check("R8 wr set", v, 8'h06);
    check("R12 byte req", {mem_req_valid, mem_op, mem_space, mem_addr, mem_wbyte},
          {1'b1, 2'd1, 2'd0, 16'h0021, 8'h3C});
    repeat (PC) @(negedge clk);
    br(3'd0, v); check("R8 wr before end", v[1], 1'b1);
    @(negedge clk);
    br(3'd0, v); check("R8 wr at end", v, 8'h04);
    check("R10 irq set", irq, 1'b1);
    bw(3'd3, 8'h00); bw(3'd6, 8'h01);
    check("R10 irq held", irq, 1'b1);
    bw(3'd6, 8'h00);
    check("R10 irq cleared", irq, 1'b0);

    // R3 / R8 busy ignores
    h0 = hs_n;
    unlock();
    bw(3'd0, 8'h06);
    bw(3'd0, 8'h04);
    br(3'd0, v); check("R3 wr not cleared", v, 8'h06);
    bw(3'd0, 8'h05);
    br(3'd0, v); check("R8 rd ignored busy", v, 8'h06);
    repeat (PC + 2) @(negedge clk);
    br(3'd0, v); check("R3 wr cleared by hw", v, 8'h04);
    check("R8 one request", hs_n, h0 + 1);
    bw(3'd6, 8'h00);

    // R11 row write
    for (int i = 0; i < RB; i++) begin
      bw(3'd3, 8'(i)); bw(3'd5, 8'(i * 7 + 3));
    end
    bw(3'd3, 8'h05);
    br(3'd5, v); check("R11 hold readback", v, 8'h26);
    bw(3'd3, 8'h45); bw(3'd4, 8'h01);
    unlock();
    bw(3'd0, 8'h86);
    check("R11 row req", {mem_req_valid, mem_op, mem_space, mem_addr}, {1'b1, 2'd2, 2'd1, 16'h0140});
    row_ok = 1'b1;
    for (int i = 0; i < RB; i++) if (mem_wrow[i*8 +: 8] !== 8'(i * 7 + 3)) row_ok = 1'b0;
    check("R11 row data", row_ok, 1'b1);
    repeat (PC + 2) @(negedge clk);
    br(3'd0, v); check("R11 row done", v, 8'h84);

    // R7 erase with back-pressure (R12)
    ready_ctl = 1'b0;
    bw(3'd3, 8'h57);
    unlock();
    bw(3'd0, 8'h96);
    check("R7 erase req", {mem_req_valid, mem_op, mem_space, mem_addr}, {1'b1, 2'd3, 2'd1, 16'h0140});
    repeat (3) @(negedge clk);
    check("R12 held", {mem_req_valid, mem_op, mem_addr}, {1'b1, 2'd3, 16'h0140});
    ready_ctl = 1'b1;
    repeat (PC + 2) @(negedge clk);
    br(3'd0, v); check("R7 free cleared", v, 8'h84);
    bw(3'd6, 8'h00);

    // R2 + R9 abort
    unlock();
    bw(3'd0, 8'hC6);
    check("R2 cfg space", {mem_req_valid, mem_op, mem_space}, {1'b1, 2'd1, 2'd2});
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    br(3'd0, v); check("R9 abort flag", v, 8'hC8);
    check("R9 no valid", mem_req_valid, 1'b0);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    br(3'd0, v); check("R9 power-on clears", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule